// File: doc/BRIEF.md
# Byte-Lane Write Control with Flow-Through Read

This block is the data-side controller of a synchronous static memory whose words are split into byte lanes of nine bits each: eight data bits and one parity bit. On every rising clock edge it samples a global write strobe, a byte-write gate and one active-low write select per lane. It turns them into lane write strobes for a small internal array. The address comes from an external sequencer and a `sel` flag says whether the device is selected.

Read data is not registered. The word at the presented address appears on `rdata` in the same cycle the address is applied. A write accepted at an edge is held in a write register, and the array is updated from that register at the following edge. While the write is pending, reads of the same address merge the held lanes into the array word. A small state machine tracks whether a write is pending. Its states are `WH_IDLE` (nothing held) and `WH_PEND` (a write is held and commits at the next edge). Its transitions are: IDLE→PEND on an accepted write, PEND→PEND on a back-to-back write (the old write commits and the new one is captured), PEND→IDLE when no write is accepted, and IDLE→IDLE otherwise.

The block also produces `bus_drive_en` for the external bidirectional data pads. This output combines the asynchronous active-low output enable, the select flag and the current cycle's write decode.

Top module: `sram_bw_ctrl`

## Requirements
- R1: Lane i of `wdata`/`rdata` occupies bits [9i+8:9i]. Bit 9i+8 is that lane's parity bit and `bw_n[i]` controls exactly that lane.
- R2: With `sel` high and `gw_n` low at a rising edge, all lanes at `addr` are written with `wdata`.
- R3: `gw_n` low writes every lane whatever the values of `bwe_n` and `bw_n`.
- R4: With `sel` high, `gw_n` high and `bwe_n` low, exactly the lanes whose `bw_n` bit is low are written. The other lanes keep their contents.
- R5: With `gw_n` high and `bwe_n` high, `bw_n` is ignored and no lane is written.
- R6: With `sel` low, nothing is written, whatever the write controls are.
- R7: `rdata` shows the stored word at `addr` in the same cycle, with no clock edge in the path.
- R8: A read of an address in the cycle right after a write to it returns the newly written lanes merged with the unwritten old lanes.
- R9: `bus_drive_en` is high only when `oe_n` is low, `sel` is high and no lane write is decoded for the current cycle.
- R10: `oe_n` acts on `bus_drive_en` without waiting for a clock edge.
- R11: Byte writes to the same address on consecutive edges accumulate, so each lane ends with its latest written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all write controls are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the write-hold state |
| sel | input | 1 | Device selected for this cycle |
| addr | input | AW | Word address from the sequencer |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 9*LANES | Write word, nine bits per lane |
| rdata | output | 9*LANES | Flow-through read word |
| bus_drive_en | output | 1 | Enable for the external data pad drivers |

## Verification
Writes are tried as global writes, as global writes with all byte selects idle, as single-lane byte writes with a different value per lane, and as byte writes while the byte-write gate is high or the device is deselected. These patterns separate the override, gating and selection rules. Reads follow writes to the same address directly, and byte writes to one address run back to back, so that the pending-write merge is exercised. `oe_n` is toggled in the middle of a cycle to show that its effect is combinational.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;
    localparam int LANE_W = 9;

    typedef enum logic {
        WH_IDLE = 1'b0,
        WH_PEND = 1'b1
    } wh_state_e;
endpackage

// File: rtl/sram_bw_decode.sv
module sram_bw_decode #(
    parameter int LANES = 4
) (
    input  logic             sel,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we,
    output logic             we_any
);
    // Global write wins; byte selects pass only through the byte-write gate.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = sel & (~gw_n | (~bwe_n & ~bw_n[g]));
    end

    assign we_any = |lane_we;
endmodule

// File: rtl/sram_bw_hold.sv
module sram_bw_hold
    import sram_bw_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 4,
    localparam int DW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_we,
    input  logic             we_any,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [LANES-1:0] commit_we,
    output logic [AW-1:0]    commit_addr,
    output logic [DW-1:0]    commit_data
);
    wh_state_e        state_q, state_d;
    logic [LANES-1:0] hold_we_q;
    logic [AW-1:0]    hold_addr_q;
    logic [DW-1:0]    hold_data_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WH_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WH_IDLE: state_d = we_any ? WH_PEND : WH_IDLE;
            WH_PEND: state_d = we_any ? WH_PEND : WH_IDLE;
            default: state_d = WH_IDLE;
        endcase
    end

    // Write register: captures the accepted write for commit next edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_we_q <= '0;
        end else if (we_any) begin
            hold_we_q <= lane_we;
        end
    end

    always_ff @(posedge clk) begin
        if (we_any) begin
            hold_addr_q <= addr;
            hold_data_q <= wdata;
        end
    end

    // Outputs
    always_comb begin
        commit_we = '0;
        unique case (state_q)
            WH_IDLE: commit_we = '0;
            WH_PEND: commit_we = hold_we_q;
            default: commit_we = '0;
        endcase
    end

    assign commit_addr = hold_addr_q;
    assign commit_data = hold_data_q;
endmodule

// File: rtl/sram_bw_array.sv
module sram_bw_array
    import sram_bw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int AW     = 4,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic [LANES-1:0] commit_we,
    input  logic [AW-1:0]    commit_addr,
    input  logic [DW-1:0]    commit_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    arr_rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (commit_we[g]) mem[commit_addr] <= commit_data[g*LANE_W +: LANE_W];
        end

        assign arr_rdata[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/sram_bw_merge.sv
module sram_bw_merge
    import sram_bw_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 4,
    localparam int DW   = LANES * LANE_W
) (
    input  logic [LANES-1:0] commit_we,
    input  logic [AW-1:0]    commit_addr,
    input  logic [DW-1:0]    commit_data,
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    arr_rdata,
    output logic [DW-1:0]    rdata
);
    logic addr_hit;
    assign addr_hit = (commit_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] = (addr_hit && commit_we[g])
                                         ? commit_data[g*LANE_W +: LANE_W]
                                         : arr_rdata[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sram_bw_ctrl.sv
module sram_bw_ctrl
    import sram_bw_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 4,
    localparam int DW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [AW-1:0]    addr,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             bus_drive_en
);
    logic [LANES-1:0] lane_we;
    logic             we_any;
    logic [LANES-1:0] commit_we;
    logic [AW-1:0]    commit_addr;
    logic [DW-1:0]    commit_data;
    logic [DW-1:0]    arr_rdata;

    sram_bw_decode #(.LANES(LANES)) u_decode (
        .sel     (sel),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we),
        .we_any  (we_any)
    );

    sram_bw_hold #(.LANES(LANES), .AW(AW)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_we     (lane_we),
        .we_any      (we_any),
        .addr        (addr),
        .wdata       (wdata),
        .commit_we   (commit_we),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    sram_bw_array #(.LANES(LANES), .AW(AW)) u_array (
        .clk         (clk),
        .commit_we   (commit_we),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .rd_addr     (addr),
        .arr_rdata   (arr_rdata)
    );

    sram_bw_merge #(.LANES(LANES), .AW(AW)) u_merge (
        .commit_we   (commit_we),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .rd_addr     (addr),
        .arr_rdata   (arr_rdata),
        .rdata       (rdata)
    );

    // Asynchronous output-enable path; any decoded write mutes the pads.
    assign bus_drive_en = ~oe_n & sel & ~we_any;
endmodule

// File: rtl/sram_bw_ctrl_chk.sv
module sram_bw_ctrl_chk #(
    parameter int LANES = 4,
    parameter int AW    = 4,
    localparam int DW   = LANES * 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic [AW-1:0]    addr,
    input logic             gw_n,
    input logic             bwe_n,
    input logic [LANES-1:0] bw_n,
    input logic             oe_n,
    input logic [DW-1:0]    wdata,
    input logic [DW-1:0]    rdata,
    input logic             bus_drive_en
);
    // R9
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !bus_drive_en);

    // R2
    gw_mutes_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !gw_n) |-> !bus_drive_en);

    // R5
    bwe_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && gw_n && bwe_n && !oe_n) |-> bus_drive_en);

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_drive_en);

    // R8
    raw_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel && !gw_n) && addr == $past(addr)) |-> rdata == $past(wdata));

    for (genvar g = 0; g < LANES; g++) begin : g_keep
        // R4
        lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(sel && gw_n && !bwe_n && bw_n[g]) && addr == $past(addr))
            |-> rdata[g*9 +: 9] == $past(rdata[g*9 +: 9]));
    end
endmodule

bind sram_bw_ctrl sram_bw_ctrl_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (sel),
    .addr         (addr),
    .gw_n         (gw_n),
    .bwe_n        (bwe_n),
    .bw_n         (bw_n),
    .oe_n         (oe_n),
    .wdata        (wdata),
    .rdata        (rdata),
    .bus_drive_en (bus_drive_en)
);

// File: tb/sram_bw_ctrl_tb.sv
module sram_bw_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int LANES = 4;
    localparam int AW    = 4;
    localparam int DW    = LANES * 9;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sel = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             gw_n = 1'b1;
    logic             bwe_n = 1'b1;
    logic [LANES-1:0] bw_n = '1;
    logic             oe_n = 1'b1;
    logic [DW-1:0]    wdata = '0;
    logic [DW-1:0]    rdata;
    logic             bus_drive_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [DW-1:0] exp_rd;
        bit            rd_valid;
        logic          exp_drv;
        string         req;
    } item_t;

    item_t         sb_q[$];
    event          chk_ev;
    logic [DW-1:0] model [DEPTH];
    bit            valid [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    sram_bw_ctrl #(.LANES(LANES), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .bus_drive_en(bus_drive_en)
    );

    task automatic chk1(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s bus_drive_en actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Monitor: pops the expected item and compares at mid-cycle
    initial begin
        forever begin
            @(chk_ev);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk1(bus_drive_en, it.exp_drv, it.req);
                if (it.rd_valid) begin
                    checks++;
                    if (rdata !== it.exp_rd) begin
                        failures++;
                        $display("FAIL %s rdata actual=%h expected=%h", it.req, rdata, it.exp_rd);
                    end
                end
            end
        end
    end

    // Driver: one clock cycle of stimulus plus the expected result
    task automatic cyc(input logic s, input logic g, input logic b,
                       input logic [LANES-1:0] bw, input logic o,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string req);
        item_t it;
        logic [LANES-1:0] we;
        @(negedge clk);
        sel = s; gw_n = g; bwe_n = b; bw_n = bw; oe_n = o; addr = a; wdata = d;
        for (int i = 0; i < LANES; i++) we[i] = s & (~g | (~b & ~bw[i]));
        it.exp_rd   = model[a];
        it.rd_valid = valid[a];
        it.exp_drv  = ~o & s & ~(|we);
        it.req      = req;
        sb_q.push_back(it);
        #(CLK_P/4);
        ->chk_ev;
        #1;
        for (int i = 0; i < LANES; i++)
            if (we[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
        if (&we) valid[a] = 1'b1;
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        logic [DW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*9 +: 9] = 9'((k * 37 + i * 101 + 5) ^ (i << 8));
        return v;
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        oe_n = 1'b0;
        #1 chk1(bus_drive_en, 1'b0, "R9 reset deselected");
        rst_n = 1'b1;

        // R2: fill every word with global writes
        for (int k = 0; k < DEPTH; k++) cyc(1, 0, 1, '1, 0, AW'(k), pat(k), "R2");
        // R7: flow-through reads of every word, address changing each cycle
        for (int k = DEPTH - 1; k >= 0; k--) cyc(1, 1, 1, '1, 0, AW'(k), '0, "R7");

        // R3: global write with byte gate low and selects idle
        cyc(1, 0, 0, '1, 0, 4'd3, pat(100), "R3");
        cyc(1, 1, 1, '1, 0, 4'd3, '0, "R3 R8");

        // R1/R4: one lane at a time, distinct lane values
        for (int i = 0; i < LANES; i++) begin
            cyc(1, 1, 0, ~(LANES'(1) << i), 0, 4'd5, pat(200 + i), "R1 R4");
            cyc(1, 1, 1, '1, 0, 4'd5, '0, "R1 R4 R8");
        end

        // R5: byte selects active but gate high
        cyc(1, 1, 1, '0, 0, 4'd6, pat(300), "R5");
        cyc(1, 1, 1, '1, 0, 4'd6, '0, "R5");

        // R6: deselected global write
        cyc(0, 0, 0, '0, 0, 4'd7, pat(400), "R6");
        cyc(1, 1, 1, '1, 0, 4'd7, '0, "R6");

        // R11: back-to-back byte writes to one address
        cyc(1, 1, 0, 4'b1110, 0, 4'd9, pat(500), "R11");
        cyc(1, 1, 0, 4'b0101, 0, 4'd9, pat(501), "R11");
        cyc(1, 1, 0, 4'b0111, 0, 4'd9, pat(502), "R11");
        cyc(1, 1, 1, '1, 0, 4'd9, '0, "R11 R8");
        cyc(1, 1, 1, '1, 0, 4'd2, '0, "R11");
        cyc(1, 1, 1, '1, 0, 4'd9, '0, "R11");

        // R9: reads with output enable off
        cyc(1, 1, 1, '1, 1, 4'd4, '0, "R9");

        // R10: output enable changed inside a cycle
        @(negedge clk);
        sel = 1; gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 1;
        #1 chk1(bus_drive_en, 1'b0, "R10 oe high");
        oe_n = 0;
        #1 chk1(bus_drive_en, 1'b1, "R10 oe low");
        oe_n = 1;
        #1 chk1(bus_drive_en, 1'b0, "R10 oe high again");

        @(negedge clk);
        sel = 0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule